// File: doc/BRIEF.md
# Two-Wire Debug Register-Access Slave

This block is the target end of a two-wire serial debug port. The master drives a serial clock line. Both sides share one open-drain data line, which is pulled high outside the chip. The slave waits for a start condition and then takes in an address byte. That byte holds a 7-bit register address, most significant bit first, followed by a direction bit. After that the slave moves bytes between the data line and a plain register-file port, which has an address, write data, a one-cycle write strobe and combinational read data.

Each byte on the line is followed by one separator slot, and the master always drives that slot. A 0 there continues the transfer and a 1 ends it. A burst keeps going for as long as the master sends 0 separators, and the register address steps by one after every data byte, wrapping within 128 registers. Both serial lines are synchronized into the system clock domain, and the system clock must run at least four times as fast as the serial clock.

Top module: `dbg2w_slave`

## Requirements
- R1: A falling data line while the serial clock is high is a start condition. It puts the slave into the address phase from any state and drops any partly received byte, so no write happens for it.
- R2: The address byte carries 7 address bits, most significant first, then one direction bit: 1 selects read and 0 selects write. The data line is sampled on rising serial-clock edges.
- R3: The ninth slot after every byte is a separator that the master drives. A 1 returns the slave to idle, where serial clocks are ignored until the next start. A 0 continues the transfer.
- R4: Write data is received most significant bit first. Each completed write byte gives exactly one `reg_we` pulse, one system clock long, with `reg_addr` set to the current address and `reg_wdata` set to the byte.
- R5: On a read, `reg_rdata` for the current address is loaded on the first falling serial-clock edge after the separator. Its bits are then driven most significant first, with `dbg_dat_oe` = 1 pulling the line low for a 0 bit. The output enable changes only while the serial clock is low.
- R6: In a burst, the address increments by one at every separator that follows a data byte, for reads and writes alike, and wraps modulo 128. The separator after the address byte does not increment it.
- R7: `dbg_dat_oe` stays 0 when idle, during the address byte, during write data and during every separator slot.
- R8: After reset, `dbg_dat_oe` = 0, `reg_we` = 0 and `reg_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_clk_i | input | 1 | Serial clock from the master |
| dbg_dat_i | input | 1 | Data line level as seen at the pad |
| dbg_dat_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 7 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write strobe |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
A burst write that starts at address 0x7E and a burst read that crosses 0x3F to 0x40 test wrapping and stepping. A counter that failed to wrap, or that also stepped on the address separator, would write or return the wrong registers. A start in the middle of a data byte, and an address byte closed with a 1 separator, must both leave the register file untouched; a slave that kept its bit count or skipped the separator would produce a stray strobe. During every master-driven high clock phase the bench watches the output enable, so a slave that held the line through a separator would be seen corrupting the master's bit.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } phase_e;
endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic prv_o
);
  logic [STAGES-1:0] chain_q;
  logic              prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prv_q   <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prv_q   <= chain_q[STAGES-1];
    end
  end

  assign lvl_o = chain_q[STAGES-1];
  assign prv_o = prv_q;
endmodule

// File: rtl/dbg2w_ctrl.sv
module dbg2w_ctrl
  import dbg2w_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_prv,
  input  logic              sda_lvl,
  input  logic              sda_prv,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              sda_oe
);
  localparam logic [CNT_W-1:0] SEP_IDX  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  phase_e              state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-2:0]   sh_q, sh_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [BYTE_W-1:0]   wd_q, wd_d;
  logic                rw_q, rw_d;
  logic                oe_q, oe_d;
  logic                we_q, we_d;

  logic scl_rise, scl_fall, start;
  assign scl_rise = scl_lvl & ~scl_prv;
  assign scl_fall = ~scl_lvl & scl_prv;
  assign start    = scl_lvl & scl_prv & sda_prv & ~sda_lvl;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    if (start) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (scl_rise) begin
      unique case (state_q)
        ST_ADDR: begin
          if (cnt_q < SEP_IDX) begin
            sh_d  = {sh_q[BYTE_W-3:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
              addr_d = sh_q;
              rw_d   = sda_lvl;
            end
          end else begin
            cnt_d   = '0;
            state_d = sda_lvl ? ST_IDLE : (rw_q ? ST_RDATA : ST_WDATA);
          end
        end
        ST_WDATA: begin
          if (cnt_q < SEP_IDX) begin
            sh_d  = {sh_q[BYTE_W-3:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
              we_d = 1'b1;
              wd_d = {sh_q, sda_lvl};
            end
          end else begin
            cnt_d  = '0;
            addr_d = addr_q + 1'b1;
            if (sda_lvl) state_d = ST_IDLE;
          end
        end
        ST_RDATA: begin
          if (cnt_q < SEP_IDX) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            cnt_d  = '0;
            addr_d = addr_q + 1'b1;
            if (sda_lvl) state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end else if (scl_fall && state_q == ST_RDATA) begin
      if (cnt_q == '0) begin
        sh_d = reg_rdata[BYTE_W-2:0];
        oe_d = ~reg_rdata[BYTE_W-1];
      end else if (cnt_q < SEP_IDX) begin
        sh_d = {sh_q[BYTE_W-3:0], 1'b0};
        oe_d = ~sh_q[BYTE_W-2];
      end else begin
        oe_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wd_q;
  assign reg_we    = we_q;
  assign sda_oe    = oe_q;

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R4
  we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(state_q) == ST_WDATA);

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RDATA) |-> !oe_q);

  // R5
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl);

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WDATA || state_q == ST_RDATA) && scl_rise && cnt_q == SEP_IDX)
    |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SEP_IDX);
endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
  import dbg2w_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_clk_i,
  input  logic              dbg_dat_i,
  output logic              dbg_dat_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [BYTE_W-1:0] reg_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_ctl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ctl_n = rst_sync_q[1];

  logic scl_lvl, scl_prv, sda_lvl, sda_prv;

  dbg2w_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_ctl_n), .pin_i(dbg_clk_i),
    .lvl_o(scl_lvl), .prv_o(scl_prv)
  );

  dbg2w_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_ctl_n), .pin_i(dbg_dat_i),
    .lvl_o(sda_lvl), .prv_o(sda_prv)
  );

  dbg2w_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ctl_n),
    .scl_lvl   (scl_lvl),
    .scl_prv   (scl_prv),
    .sda_lvl   (sda_lvl),
    .sda_prv   (sda_prv),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .sda_oe    (dbg_dat_oe)
  );
endmodule

// File: tb/dbg2w_slave_tb.sv
module dbg2w_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 60;
  localparam int QTR        = 20;
  localparam int WDOG_CYC   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       dat_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       line;

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];
  logic [6:0] wr_addr [64];
  logic [7:0] wr_dat  [64];
  int         wr_n = 0;
  int         we_long = 0;
  int         oe_bad = 0;
  logic       we_prev = 1'b0;
  logic       mdrv = 1'b0;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line      = m_sda & ~dat_oe;
  assign reg_rdata = mem[reg_addr];

  dbg2w_slave u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_clk_i(m_scl), .dbg_dat_i(line),
    .dbg_dat_oe(dat_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(negedge clk) begin
    if (reg_we) begin
      if (wr_n < 64) begin
        wr_addr[wr_n] = reg_addr;
        wr_dat[wr_n]  = reg_wdata;
      end
      wr_n = wr_n + 1;
      mem[reg_addr] = reg_wdata;
    end
    if (reg_we && we_prev) we_long = we_long + 1;
    we_prev = reg_we;
    if (mdrv && m_scl && dat_oe) oe_bad = oe_bad + 1;
  end

  localparam logic [23:0] VEC [7] = '{
    {1'b0, 7'h10, 8'd1, 8'hA5},
    {1'b1, 7'h10, 8'd1, 8'h00},
    {1'b0, 7'h7E, 8'd3, 8'h30},
    {1'b1, 7'h7E, 8'd3, 8'h00},
    {1'b1, 7'h05, 8'd2, 8'h00},
    {1'b0, 7'h40, 8'd2, 8'hFF},
    {1'b1, 7'h3F, 8'd3, 8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run = n_run + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic start_cond();
    mdrv = 1'b0;
    #QTR m_sda = 1'b1;
    #(HALF-QTR) m_scl = 1'b1;
    #HALF m_sda = 1'b0;
    #HALF m_scl = 1'b0;
  endtask

  task automatic wbit(input logic b);
    mdrv = 1'b1;
    #QTR m_sda = b;
    #(HALF-QTR) m_scl = 1'b1;
    #HALF m_scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    mdrv = 1'b0;
    #QTR m_sda = 1'b1;
    #(HALF-QTR) m_scl = 1'b1;
    #(HALF/2) b = line;
    #(HALF/2) m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rd);
    for (int i = 6; i >= 0; i--) wbit(a[i]);
    wbit(rd);
  endtask

  task automatic xfer(input logic rd, input logic [6:0] a, input int n, input logic [7:0] seed);
    logic [7:0] v;
    logic [6:0] ca;
    int nb;
    start_cond();
    send_addr(a, rd);
    wbit(1'b0);
    for (int k = 0; k < n; k++) begin
      ca = a + 7'(k);
      if (rd) begin
        for (int i = 7; i >= 0; i--) begin
          logic b;
          rbit(b);
          v[i] = b;
        end
        wbit(k == n - 1);
        // R5 read bits msb first; R6 address steps and wraps
        chk(v == exp_mem[ca], "R5/R6 read data", int'(v), int'(exp_mem[ca]));
      end else begin
        v  = seed + 8'(k);
        nb = wr_n;
        send_byte(v);
        wbit(k == n - 1);
        exp_mem[ca] = v;
        // R4 one strobe with address and data; R6 address step
        chk(wr_n == nb + 1 && wr_addr[nb] == ca && wr_dat[nb] == v,
            "R4/R6 write strobe", int'({wr_addr[nb], wr_dat[nb]}), int'({ca, v}));
      end
    end
  endtask

  initial begin
    #(WDOG_CYC * CLK_PERIOD);
    if (!done) begin
      n_run = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int nb;
    for (int a = 0; a < 128; a++) begin
      mem[a]     = 8'((a * 7 + 3) & 255);
      exp_mem[a] = 8'((a * 7 + 3) & 255);
    end
    #(5*CLK_PERIOD) rst_n = 1'b1;
    #(5*CLK_PERIOD + 2);

    // R8 reset state
    chk(dat_oe == 1'b0 && reg_we == 1'b0 && reg_addr == 7'd0, "R8 reset state",
        int'({dat_oe, reg_we, reg_addr}), 0);

    // R3 idle slave ignores clocks before any start
    m_scl = 1'b0;
    nb = wr_n;
    send_byte(8'h3C);
    wbit(1'b0);
    chk(wr_n == nb && dat_oe == 1'b0, "R3 idle ignores clocks", wr_n - nb, 0);

    for (int t = 0; t < 7; t++) begin
      logic [23:0] v;
      v = VEC[t];
      xfer(v[23], v[22:16], int'(v[15:8]), v[7:0]);
    end

    // R3 clocks after a 1 separator are ignored
    nb = wr_n;
    send_byte(8'h99);
    wbit(1'b0);
    chk(wr_n == nb, "R3 ignored after end separator", wr_n - nb, 0);

    // R1 start in mid-byte aborts the partial byte
    nb = wr_n;
    start_cond();
    send_addr(7'h22, 1'b0);
    wbit(1'b0);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    start_cond();
    send_addr(7'h23, 1'b0);
    wbit(1'b0);
    send_byte(8'h5C);
    wbit(1'b1);
    exp_mem[7'h23] = 8'h5C;
    chk(wr_n == nb + 1 && wr_addr[nb] == 7'h23 && wr_dat[nb] == 8'h5C,
        "R1 restart after abort", int'({wr_addr[nb], wr_dat[nb]}), int'({7'h23, 8'h5C}));
    xfer(1'b1, 7'h22, 2, 8'h00);

    // R3 a 1 separator after the address byte ends the transfer
    nb = wr_n;
    start_cond();
    send_addr(7'h30, 1'b0);
    wbit(1'b1);
    send_byte(8'hE7);
    wbit(1'b1);
    chk(wr_n == nb, "R3 address separator end", wr_n - nb, 0);

    // R2 direction bit: read of 0x30 returns untouched contents
    xfer(1'b1, 7'h30, 1, 8'h00);

    // R4 every strobe exactly one cycle
    chk(we_long == 0, "R4 strobe width", we_long, 0);
    // R7 line released whenever the master drives
    chk(oe_bad == 0, "R7 release while master drives", oe_bad, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule